// File: doc/BRIEF.md
# Four-Lane 7:1 Serial Video Receiver

This block recovers raw 8-bit pixel video from a four-lane serial camera link in its narrowest configuration. Each of the four data lanes, and a fifth lane that carries the link clock pattern, is sampled once per cycle of a bit clock running at seven times the pixel rate. A per-lane shift register collects seven bits per pixel, and the four data lanes together give one 28-bit word per pixel period. The pixel rate is not a separate input. The receiver derives it from the bit clock by counting seven-bit windows.

Alignment of the window boundary is found on the clock lane. The receiver moves its window by one bit after each window whose clock-lane bits do not read the expected pattern. It declares lock after sixteen consecutive matching windows. Once locked, it extracts the 8-bit pixel and the frame, line and data qualifier bits from each word. It presents them as pixel data with active-video, horizontal-sync and vertical-sync outputs and a one-cycle pixel strobe. Raw mosaic pixel values pass through unchanged.

Top module: `cl_base_rx`

## Requirements
- R1: While `rst_n` is low, `pix_valid`, `locked`, `active_video`, `hsync`, `vsync` and `pix_data` are all 0.
- R2: `locked` rises only at the end of the 16th consecutive window whose clock-lane bits match the pattern, and `pix_valid` is never high while `locked` is low. With windows aligned from the first bit after reset, the first pixel delivered is word 15.
- R3: For data lane k (k = 0..3), the seven bits of one window fill word bits 7k+6 down to 7k, with the first bit received going to 7k+6. The clock-lane pattern, taken first bit first, is 1100011. Words come out in the order they were sent, without gaps, while lock holds.
- R4: The pixel is taken from word bits as follows: pixel bits 4..0 come from word bits 4..0, pixel bit 5 from word bit 6, pixel bit 6 from word bit 27, and pixel bit 7 from word bit 5.
- R5: `active_video` equals frame-valid AND line-valid AND data-valid, where line-valid is word bit 24, frame-valid is word bit 25 and data-valid is word bit 26.
- R6: `hsync` is the inverse of line-valid and `vsync` is the inverse of frame-valid for the delivered word.
- R7: `pix_valid` is high for exactly one bit-clock cycle per delivered word. It rises on the second rising edge after the edge that samples the window's last bit, and all video outputs keep their values until the next delivered word.
- R8: A locked window whose clock-lane bits do not match the pattern drops `locked` at once and delivers no pixel for that word. The window then slips one bit, and delivery resumes after seven windows of realignment and sixteen matching windows.
- R9: From any starting bit offset 0..6 of the stream relative to reset release, the receiver slips one bit per mismatching window. The first pixel delivered is word offset+15.
- R10: Word bits other than 0..6 and 24..27 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_clk_lane | input | 1 | Sampled clock-pattern lane |
| cl_data | input | 4 | Sampled serial data lanes, bit k is lane k |
| pix_data | output | 8 | Recovered pixel |
| pix_valid | output | 1 | One-cycle strobe per delivered word |
| active_video | output | 1 | Frame, line and data qualifiers all set |
| hsync | output | 1 | High while line-valid is low |
| vsync | output | 1 | High while frame-valid is low |
| locked | output | 1 | Word alignment established |

## Verification
The bench builds the receiver with its default lock threshold of 16 windows. That keeps full realignment from every one of the seven bit offsets, and relock after a corrupted clock window, within a stream of 120 words. With these values the exact index of the first delivered word can be predicted and checked: offset+15 after reset, and word 83 after a glitch at word 60. The bench alternates all-zero and all-one filler in the unused word bits, so any leak from those bits would change a delivered pixel or qualifier.

// File: rtl/clrx_pkg.sv
package clrx_pkg;
  localparam int SER_W   = 7;
  localparam int N_LANES = 4;
  localparam int WORD_W  = SER_W * N_LANES;
  localparam int PIX_W   = 8;
  localparam logic [SER_W-1:0] CLK_PATTERN = 7'b1100011;

  // word bit positions that neighbours decode
  localparam int LV_BIT = 24;
  localparam int FV_BIT = 25;
  localparam int DV_BIT = 26;

  typedef struct packed {
    logic             fval;
    logic             lval;
    logic             dval;
    logic [PIX_W-1:0] pix;
  } clrx_fields_t;

  function automatic clrx_fields_t unpack_word(input logic [WORD_W-1:0] w);
    clrx_fields_t f;
    f.pix  = {w[5], w[27], w[6], w[4:0]};
    f.lval = w[LV_BIT];
    f.fval = w[FV_BIT];
    f.dval = w[DV_BIT];
    return f;
  endfunction
endpackage

// File: rtl/cl_lane_deser.sv
module cl_lane_deser #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sin,
  output logic [W-1:0] sr
);
  logic [W-1:0] sr_q, sr_d;

  // newest bit enters at the bottom; the first bit of a window ends at the top
  always_comb sr_d = {sr_q[W-2:0], sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr = sr_q;
endmodule

// File: rtl/cl_word_align.sv
module cl_word_align
  import clrx_pkg::*;
#(
  parameter int LOCK_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SER_W-1:0] clk_sr,
  output logic             win_end,
  output logic             locked
);
  localparam int PH_W = $clog2(SER_W);
  localparam int CW   = $clog2(LOCK_CNT + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SER_W - 1);
  localparam logic [CW-1:0]   CNT_MAX = CW'(LOCK_CNT);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            win_q, win_d;
  logic            lock_q, lock_d;
  logic            match;

  assign match = (clk_sr == CLK_PATTERN);

  always_comb begin
    ph_d  = ph_q;
    win_d = 1'b0;
    cnt_d = cnt_q;
    if (win_q && !match) begin
      ph_d = ph_q;                       // slip: stretch this window by one bit
    end else if (ph_q == PH_LAST) begin
      ph_d  = '0;
      win_d = 1'b1;
    end else begin
      ph_d = ph_q + 1'b1;
    end
    if (win_q) begin
      if (!match)                cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
    lock_d = (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      win_q  <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign win_end = win_q;
  assign locked  = lock_q;

  p_win_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |=> !win_q);
  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !match) |=> !lock_q);
  p_lock_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(win_q && match));
endmodule

// File: rtl/cl_word_decode.sv
module cl_word_decode
  import clrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_end,
  input  logic              locked,
  input  logic [WORD_W-1:0] word,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid,
  output logic              active_video,
  output logic              hsync,
  output logic              vsync
);
  clrx_fields_t     fld_q, fld_d;
  logic             wv_q, wv_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             pv_q, pv_d, act_q, act_d, hs_q, hs_d, vs_q, vs_d;
  logic             upd;

  always_comb begin
    wv_d  = win_end;
    fld_d = win_end ? unpack_word(word) : fld_q;   // stage 1 enable
    upd   = wv_q && locked;                          // stage 2 enable
    pv_d  = upd;
    pix_d = upd ? fld_q.pix : pix_q;
    act_d = upd ? (fld_q.fval && fld_q.lval && fld_q.dval) : act_q;
    hs_d  = upd ? !fld_q.lval : hs_q;
    vs_d  = upd ? !fld_q.fval : vs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
      wv_q  <= 1'b0;
      pix_q <= '0;
      pv_q  <= 1'b0;
      act_q <= 1'b0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      fld_q <= fld_d;
      wv_q  <= wv_d;
      pix_q <= pix_d;
      pv_q  <= pv_d;
      act_q <= act_d;
      hs_q  <= hs_d;
      vs_q  <= vs_d;
    end
  end

  assign pix_data     = pix_q;
  assign pix_valid    = pv_q;
  assign active_video = act_q;
  assign hsync        = hs_q;
  assign vsync        = vs_q;

  p_sync_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && act_q) |-> (!hs_q && !vs_q));
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |=> !pv_q);
endmodule

// File: rtl/cl_base_rx.sv
module cl_base_rx
  import clrx_pkg::*;
#(
  parameter int LOCK_CNT = 16
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             cl_clk_lane,
  input  logic [N_LANES-1:0] cl_data,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_valid,
  output logic             active_video,
  output logic             hsync,
  output logic             vsync,
  output logic             locked
);
  localparam int ALL_LANES = N_LANES + 1;

  logic [ALL_LANES-1:0]            lane_in;
  logic [ALL_LANES-1:0][SER_W-1:0] lane_sr;
  logic [WORD_W-1:0]               word;
  logic                            win_end;

  assign lane_in = {cl_data, cl_clk_lane};

  for (genvar i = 0; i < ALL_LANES; i++) begin : g_lane
    cl_lane_deser #(.W(SER_W)) u_deser (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .sin   (lane_in[i]),
      .sr    (lane_sr[i])
    );
  end

  for (genvar k = 0; k < N_LANES; k++) begin : g_word
    assign word[SER_W*k +: SER_W] = lane_sr[k+1];
  end

  cl_word_align #(.LOCK_CNT(LOCK_CNT)) u_align (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .clk_sr  (lane_sr[0]),
    .win_end (win_end),
    .locked  (locked)
  );

  cl_word_decode u_decode (
    .clk          (clk_bit),
    .rst_n        (rst_n),
    .win_end      (win_end),
    .locked       (locked),
    .word         (word),
    .pix_data     (pix_data),
    .pix_valid    (pix_valid),
    .active_video (active_video),
    .hsync        (hsync),
    .vsync        (vsync)
  );

  p_valid_locked_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
    pix_valid |-> locked);
endmodule

// File: tb/cl_base_rx_bench.sv
module cl_base_rx_bench;
  logic       clk_bit = 1'b0;
  logic       rst_n;
  logic       cl_clk_lane;
  logic [3:0] cl_data;
  logic [7:0] pix_data;
  logic       pix_valid, active_video, hsync, vsync, locked;

  cl_base_rx u_cl_base_rx (
    .clk_bit(clk_bit), .rst_n(rst_n), .cl_clk_lane(cl_clk_lane), .cl_data(cl_data),
    .pix_data(pix_data), .pix_valid(pix_valid), .active_video(active_video),
    .hsync(hsync), .vsync(vsync), .locked(locked)
  );

  always #2.5 clk_bit = ~clk_bit;

  int cyc = 0;
  always @(posedge clk_bit) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;

  int exp_cyc [256];
  int seq_of  [256];
  bit fv_of [256], lv_of [256], dv_of [256], sent [256];
  bit mon_en = 0;
  int last_seq, first_seq, n_out, gap_from, gap_to;

  localparam int N_WORDS = 120;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every delivered word is compared with the word the bench sent
  always @(negedge clk_bit) begin
    if (mon_en && pix_valid) begin
      int p;
      p = pix_data;
      chk(locked == 1'b1, "R2 strobe only while locked", locked, 1);
      chk(sent[p] == 1'b1, "R4 pixel bit mapping", p, 0);
      if (sent[p]) begin
        chk(cyc == exp_cyc[p], "R7 latency", cyc, exp_cyc[p]);
        chk(active_video == (fv_of[p] & lv_of[p] & dv_of[p]), "R5 active video",
            active_video, fv_of[p] & lv_of[p] & dv_of[p]);
        chk(hsync == !lv_of[p], "R6 hsync", hsync, !lv_of[p]);
        chk(vsync == !fv_of[p], "R6 vsync", vsync, !fv_of[p]);
        chk(seq_of[p] > last_seq, "R3 word order", seq_of[p], last_seq + 1);
        if (first_seq < 0) first_seq = seq_of[p];
        else if (seq_of[p] != last_seq + 1 && gap_from < 0) begin
          gap_from = last_seq;
          gap_to   = seq_of[p];
        end
        last_seq = seq_of[p];
        n_out++;
      end
    end
  end

  // drives one bit per lane; called at a falling edge, returns at the next one
  task automatic drive_bit(input bit c, input logic [3:0] d);
    cl_clk_lane = c;
    cl_data     = d;
    @(negedge clk_bit);
  endtask

  task automatic send_word(input int idx, input int seed, input bit junk,
                           input logic [6:0] pat);
    logic [27:0] x;
    int p;
    bit f, l, d;
    p = (idx * 37 + seed) & 255;
    f = ((idx + seed) % 40) < 34;
    l = ((idx + seed) % 9) < 7;
    d = ((idx + seed) % 4) != 3;
    x = junk ? '1 : '0;                // R10 filler in bits the block must ignore
    x[4:0] = p[4:0];
    x[6]   = p[5];
    x[27]  = p[6];
    x[5]   = p[7];
    x[24]  = l;
    x[25]  = f;
    x[26]  = d;
    seq_of[p] = idx; fv_of[p] = f; lv_of[p] = l; dv_of[p] = d; sent[p] = 1'b1;
    for (int j = 0; j < 7; j++) begin
      logic [3:0] dv;
      for (int k = 0; k < 4; k++) dv[k] = x[7*k + 6 - j];
      if (j == 6) exp_cyc[p] = cyc + 3;
      drive_bit(pat[6-j], dv);
    end
  endtask

  task automatic start_run(input int off);
    mon_en = 1'b0;
    rst_n = 1'b0;
    cl_clk_lane = 1'b0;
    cl_data = '0;
    for (int i = 0; i < 256; i++) begin
      sent[i] = 1'b0; exp_cyc[i] = -1; seq_of[i] = -1;
    end
    last_seq = -1; first_seq = -1; n_out = 0; gap_from = -1; gap_to = -1;
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    mon_en = 1'b1;
    for (int i = 0; i < off; i++) drive_bit(1'b0, 4'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cl_clk_lane = 1'b1;
    cl_data = 4'hF;
    repeat (4) @(negedge clk_bit);
    chk(pix_valid == 1'b0, "R1 reset pix_valid", pix_valid, 0);
    chk(locked == 1'b0, "R1 reset locked", locked, 0);
    chk(active_video == 1'b0, "R1 reset active_video", active_video, 0);
    chk(hsync == 1'b0, "R1 reset hsync", hsync, 0);
    chk(vsync == 1'b0, "R1 reset vsync", vsync, 0);
    chk(pix_data == 8'h00, "R1 reset pix_data", pix_data, 0);
  endtask

  task automatic t_stream(input int off, input int seed, input bit junk);
    start_run(off);
    for (int i = 0; i < N_WORDS; i++) send_word(i, seed, junk, 7'b1100011);
    repeat (6) @(negedge clk_bit);
    mon_en = 1'b0;
    if (off == 0) chk(first_seq == 15, "R2 first word after 16 windows", first_seq, 15);
    chk(first_seq == off + 15, "R9 alignment from offset", first_seq, off + 15);
    chk(gap_from < 0, "R3 no gap while locked", gap_from, -1);
    chk(n_out == N_WORDS - (off + 15), "R10 delivered count with filler", n_out,
        N_WORDS - (off + 15));
    chk(last_seq == N_WORDS - 1, "R3 last word delivered", last_seq, N_WORDS - 1);
  endtask

  task automatic t_glitch;
    start_run(2);
    for (int i = 0; i < N_WORDS; i++)
      send_word(i, 11, 1'b0, (i == 60) ? 7'b1100111 : 7'b1100011);
    repeat (6) @(negedge clk_bit);
    mon_en = 1'b0;
    chk(gap_from == 59, "R8 last word before loss", gap_from, 59);
    chk(gap_to == 83, "R8 first word after relock", gap_to, 83);
    chk(last_seq == N_WORDS - 1, "R8 stream resumes", last_seq, N_WORDS - 1);
  endtask

  initial begin
    rst_n = 1'b0;
    cl_clk_lane = 1'b0;
    cl_data = '0;
    @(negedge clk_bit);
    t_reset();
    for (int off = 0; off < 7; off++) t_stream(off, off * 13 + 5, off[0]);
    t_glitch();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule